// File: doc/BRIEF.md
# Set/Clear Interrupt Status and Mask Controller

This block gathers a parameterised vector of hardware event lines (32 by default) into one level interrupt. A rising edge on an event line latches a pending bit in a status register. A per-source mask register gates each pending bit away from the output. Software reaches both registers over a simple register bus, and each register has its own write-one-to-set and write-one-to-clear alias. Any number of bits can therefore be raised, cleared, masked or unmasked with a single write, and no read-modify-write sequence is needed.

All three aliases of a register read back its current value. A driver can follow each write with a read to confirm that the write has taken effect. The combined interrupt output is registered and goes high whenever any pending bit is unmasked. If an event and a software clear hit the same bit in the same cycle, the event wins, so that no edge is lost.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset the status register reads all zeros, the mask register reads all ones and irq_o is low.
- R2: A 0-to-1 transition on event_i[n] sets status bit n on the clock edge where the new level is first sampled. An event line that stays high does not set the bit again once it has been cleared.
- R3: A write to byte offset 0x04 sets every status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: A write to byte offset 0x08 clears every status bit whose write-data bit is 1, and an all-ones write clears the whole register. Write-data bits that are 0 leave their status bits unchanged.
- R5: When an event rising edge and a clear write target the same status bit in the same cycle, the bit ends up set.
- R6: A write to byte offset 0x10 sets mask bits and a write to byte offset 0x14 clears mask bits, one bit per write-data 1. Write-data bits that are 0 leave their mask bits unchanged.
- R7: A read returns its data on rdata_o with rvalid_o high in the cycle after the request. Offsets 0x00, 0x04 and 0x08 return the status register. Offsets 0x0C, 0x10 and 0x14 return the mask register. Offsets 0x18 and 0x1C return zero. The two low address bits are ignored.
- R8: irq_o equals the OR over all sources of (status AND NOT mask), registered, so it follows a register change by one clock.
- R9: Writes to offsets 0x00, 0x0C, 0x18 and 0x1C change neither register.
- R10: A read issued in the cycle after a write returns the value that the write produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Byte address |
| wdata_i | input | N_SRC (32) | Write data |
| rdata_o | output | N_SRC (32) | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| event_i | input | N_SRC (32) | Hardware event lines, sensed on rising edges |
| irq_o | output | 1 | Combined interrupt |

## Verification
A corrupted status or mask bit is visible at the ports in two ways. A read of any alias returns the bad value in the next cycle. irq_o turns wrong one cycle after the bad bit appears, but only when that bit is unmasked and pending. For this reason the directed scenarios read both registers back after every write. They also toggle the mask around a pending bit, so that a stuck mask bit or a lost pending bit shows on irq_o within two cycles. An edge detector that misbehaves shows up as a status bit that comes back after a clear while its event line is held high. It also shows up as a bit that is lost when an event and a clear write collide.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;
  // word index = byte offset >> 2; software depends on this order
  typedef enum logic [2:0] {
    W_STAT  = 3'd0,
    W_SSET  = 3'd1,
    W_SCLR  = 3'd2,
    W_MSTAT = 3'd3,
    W_MSET  = 3'd4,
    W_MCLR  = 3'd5
  } word_e;

  typedef struct packed {
    logic st_set;
    logic st_clr;
    logic mk_set;
    logic mk_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irq_setclr_decode.sv
module irq_setclr_decode
  import irq_setclr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        strb_o,
  output logic [2:0]        word_o,
  output logic              rd_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_full;
  logic              in_range;
  logic              wr;

  assign word_full = addr_i[ADDR_W-1:2];
  assign word_o    = word_full[2:0];
  generate
    if (WORD_W > 3) begin : g_hi
      assign in_range = (word_full[WORD_W-1:3] == '0);
    end else begin : g_lo
      assign in_range = 1'b1;
    end
  endgenerate

  assign wr = req_i & we_i & in_range;
  assign rd_o = req_i & ~we_i;

  always_comb begin
    strb_o = '0;
    if (wr) begin
      unique case (word_e'(word_o))
        W_SSET:  strb_o.st_set = 1'b1;
        W_SCLR:  strb_o.st_clr = 1'b1;
        W_MSET:  strb_o.mk_set = 1'b1;
        W_MCLR:  strb_o.mk_clr = 1'b1;
        default: strb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_setclr_status.sv
module irq_setclr_status #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] event_q;
  logic [N_SRC-1:0] rise_w;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] status_d;

  assign rise_w = event_i & ~event_q;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      // event rise beats a simultaneous clear
      assign status_d[i] = rise_w[i] | (set_i & wdata_i[i]) |
                           (status_q[i] & ~(clr_i & wdata_i[i]));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event_q  <= '0;
      status_q <= '0;
    end else begin
      event_q  <= event_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((status_o & $past(wdata_i)) == $past(wdata_i)));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((status_o & $past(wdata_i & ~rise_w)) == '0));

  p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && |(rise_w & wdata_i)) |=>
      ((status_o & $past(rise_w & wdata_i)) == $past(rise_w & wdata_i)));

  p_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_w) |=> ((status_o & $past(rise_w)) == $past(rise_w)));
endmodule

// File: rtl/irq_setclr_mask.sv
module irq_setclr_mask #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  localparam logic [N_SRC-1:0] MASK_RST = '1;

  logic [N_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= MASK_RST;
    else if (set_i) mask_q <= mask_q | wdata_i;
    else if (clr_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  p_mset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

  p_mclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((mask_o & $past(wdata_i)) == '0));

  p_mhold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irq_setclr_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              rvalid_o,
  input  logic [N_SRC-1:0]  event_i,
  output logic              irq_o
);
  wr_strobe_t       strb;
  logic [2:0]       word;
  logic             rd;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] mask;
  logic [N_SRC-1:0] rd_mux;
  logic [N_SRC-1:0] rdata_q;
  logic             rvalid_q;
  logic             irq_q;

  irq_setclr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .strb_o (strb),
    .word_o (word),
    .rd_o   (rd)
  );

  irq_setclr_status #(.N_SRC(N_SRC)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .set_i    (strb.st_set),
    .clr_i    (strb.st_clr),
    .wdata_i  (wdata_i),
    .status_o (status)
  );

  irq_setclr_mask #(.N_SRC(N_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (strb.mk_set),
    .clr_i   (strb.mk_clr),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i[ADDR_W-1:5] == '0) begin
      case (word)
        3'd0, 3'd1, 3'd2: rd_mux = status;
        3'd3, 3'd4, 3'd5: rd_mux = mask;
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
      irq_q    <= |(status & ~mask);
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;

  p_rvalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_rd_stat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:2] == '0) |=> (rdata_o == $past(status)));

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status & ~mask))));
endmodule

// File: tb/irq_setclr_ctrl_test.sv
module irq_setclr_ctrl_test;
  localparam int N = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0, ev = '0;
  logic [N-1:0]  rdata;
  logic          rvalid, irq;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  irq_setclr_ctrl #(.N_SRC(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .event_i(ev), .irq_o(irq)
  );

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    if (rvalid !== 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL R7: rvalid got %b expected 1", rvalid);
    end
    d = rdata;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    check("R1 irq", {31'd0, irq}, '0);
    rd(5'h00, d); check("R1 status", d, '0);
    rd(5'h0C, d); check("R1 mask", d, '1);
  endtask

  task automatic t_set_clr;
    logic [N-1:0] d;
    wr(5'h04, 32'h0000_00F0);
    rd(5'h00, d); check("R3 set", d, 32'h0000_00F0);
    wr(5'h04, 32'h8000_0001);
    rd(5'h08, d); check("R3 zero bits keep / R10 readback", d, 32'h8000_00F1);
    wr(5'h08, 32'h0000_0030);
    rd(5'h04, d); check("R4 partial clr", d, 32'h8000_00C1);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R4 clear all", d, '0);
  endtask

  task automatic t_event;
    logic [N-1:0] d;
    @(negedge clk); ev = 32'h0000_0400;
    @(negedge clk);
    rd(5'h00, d); check("R2 rise latch", d, 32'h0000_0400);
    wr(5'h08, 32'h0000_0400);
    @(negedge clk);
    rd(5'h00, d); check("R2 held level no reset", d, '0);
    @(negedge clk); ev = '0;
    @(negedge clk);
  endtask

  task automatic t_collide;
    logic [N-1:0] d;
    wr(5'h04, 32'h0000_0003);
    @(negedge clk); req = 1; we = 1; addr = 5'h08; wdata = 32'h0000_0003; ev = 32'h0000_0001;
    @(negedge clk); req = 0; we = 0;
    rd(5'h00, d); check("R5 event beats clr", d, 32'h0000_0001);
    ev = '0;
    wr(5'h08, '1);
  endtask

  task automatic t_mask_irq;
    logic [N-1:0] d;
    wr(5'h04, 32'h0000_0008);
    @(negedge clk);
    check("R8 masked no irq", {31'd0, irq}, '0);
    wr(5'h14, 32'h0000_0008);
    check("R8 irq lag one clock", {31'd0, irq}, '0);
    @(negedge clk);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    rd(5'h10, d); check("R6 mask clr", d, 32'hFFFF_FFF7);
    wr(5'h10, 32'h0000_0008);
    @(negedge clk);
    check("R8 irq dropped by mask", {31'd0, irq}, '0);
    rd(5'h14, d); check("R6 mask set", d, '1);
    wr(5'h14, 32'h0000_0F00);
    wr(5'h14, 32'h0000_0000);
    rd(5'h0C, d); check("R6 zero bits keep", d, 32'hFFFF_F0FF);
    wr(5'h08, '1);
    @(negedge clk);
    check("R8 irq low after clr", {31'd0, irq}, '0);
    wr(5'h10, '1);
  endtask

  task automatic t_ignored;
    logic [N-1:0] d;
    wr(5'h04, 32'h0000_1111);
    wr(5'h00, '1);
    wr(5'h0C, '0);
    wr(5'h18, '0);
    wr(5'h1C, '0);
    rd(5'h00, d); check("R9 status untouched", d, 32'h0000_1111);
    rd(5'h0C, d); check("R9 mask untouched", d, '1);
    rd(5'h18, d); check("R7 unmapped 0x18", d, '0);
    rd(5'h1F, d); check("R7 unmapped 0x1C", d, '0);
    rd(5'h0A, d); check("R7 low bits ignored", d, 32'h0000_1111);
    wr(5'h08, '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_set_clr();
    t_event();
    t_collide();
    t_mask_irq();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule